// File: doc/BRIEF.md
# Start-Gap Wear-Leveling Address Remapper

This block sits in front of a non-volatile memory of `N_LINES` logical lines that is built with `N_LINES + 1` physical lines. One physical line is always empty: it is the gap, and it holds no logical data. Two registers, a start offset and the gap position, define the mapping from logical to physical line. Every logical address is first rotated by the start offset modulo `N_LINES`. The result is then bumped by one if it lands at or above the gap.

The block counts user writes. After every `GAP_INTERVAL` of them it asks an external line-copy datapath to move the gap down by one line, which costs one extra line write. The copy moves the line just below the gap into the gap. When the gap has reached line 0, the copy moves the top line into line 0, the gap returns to the top, and the start offset advances by one. Over time this rotates the whole mapping across the array. The register cost is two small registers, and the write overhead is 1/`GAP_INTERVAL`.

Top module: `start_gap_remap`

## Requirements
- R1: After reset the start offset is 0 and the gap is at physical line `N_LINES`. Every logical address L therefore maps to physical L, and `mv_req` is low.
- R2: `phys_addr` is computed combinationally from `req_laddr` and the current registers. First T = (start + L) mod `N_LINES`. Then `phys_addr` = T + 1 when T ≥ gap, and `phys_addr` = T otherwise.
- R3: On the clock edge that takes the `GAP_INTERVAL`-th counted write, `mv_req` rises and the write counter restarts from zero. A counted write is a cycle with `req_valid` and `req_write` both high.
- R4: While `mv_req` is high, the copy addresses depend on the gap. When the gap is nonzero, `mv_src` = gap − 1 and `mv_dst` = gap. When the gap is 0, `mv_src` = `N_LINES` and `mv_dst` = 0.
- R5: `mv_req` stays high, with the mapping and copy addresses unchanged, until a cycle in which `mv_ack` is high. On that edge the move completes and `mv_req` falls.
- R6: A completed move with a nonzero gap decrements the gap. A completed move with the gap at 0 sets the gap to `N_LINES` and increments the start offset modulo `N_LINES`.
- R7: At all times the mapping of logical lines 0..`N_LINES`−1 is a bijection onto the physical lines other than the gap.
- R8: Cycles with `req_write` low are not counted, and the copy write is not counted. Writes made while a move is pending are counted, but the count saturates at `GAP_INTERVAL` − 1. The first counted write after that move completes then raises the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | Request is a write |
| req_laddr | input | AW | Logical line address |
| phys_addr | output | PW | Translated physical line address |
| mv_req | output | 1 | Gap move requested |
| mv_ack | input | 1 | Copy datapath accepts and completes the move |
| mv_src | output | PW | Physical line to copy from |
| mv_dst | output | PW | Physical line to copy into (current gap) |

## Verification
Each result has a known time at which it becomes due:

- **Translation** (`phys_addr`) depends on no register in the request path. It is read in the same cycle, a short settle delay after `req_laddr` changes.
- **Move request** (`mv_req`) and the copy addresses are registered. They appear after the edge that takes the interval-closing write, so the bench checks them at the following falling edge.
- **Register updates** from a move are visible only after the edge on which `mv_ack` is sampled high. The bench checks the full mapping at the next falling edge, against a reference start/gap model, for bijectivity and for avoiding the gap.

All stimulus changes on falling edges, so every sample is taken half a cycle away from the active edge.

// File: rtl/start_gap_remap.sv
module start_gap_remap #(
  parameter int N_LINES      = 64,
  parameter int GAP_INTERVAL = 100,
  localparam int AW = (N_LINES > 1) ? $clog2(N_LINES) : 1,
  localparam int PW = $clog2(N_LINES + 1),
  localparam int CW = $clog2(GAP_INTERVAL + 1),
  localparam int SW = PW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_laddr,
  output logic [PW-1:0] phys_addr,
  output logic          mv_req,
  input  logic          mv_ack,
  output logic [PW-1:0] mv_src,
  output logic [PW-1:0] mv_dst
);

  logic [AW-1:0] start_q;
  logic [PW-1:0] gap_q;
  logic [CW-1:0] cnt_q;
  logic          pend_q;

  logic [SW-1:0] sum, rot;
  logic          wr, last, done;

  assign sum  = SW'(start_q) + SW'(req_laddr);
  assign rot  = (sum >= SW'(N_LINES)) ? sum - SW'(N_LINES) : sum;
  assign phys_addr = PW'(rot) + {{(PW-1){1'b0}}, (rot >= SW'(gap_q))};

  assign wr   = req_valid & req_write;
  assign last = (cnt_q == CW'(GAP_INTERVAL - 1));
  assign done = pend_q & mv_ack;

  assign mv_req = pend_q;
  assign mv_dst = gap_q;
  assign mv_src = (gap_q == '0) ? PW'(N_LINES) : gap_q - PW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (wr) begin
        if (!pend_q && last) begin
          pend_q <= 1'b1;
          cnt_q  <= '0;
        end else if (!last) begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
      if (done) pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      gap_q   <= PW'(N_LINES);
    end else if (done) begin
      if (gap_q == '0) begin
        gap_q   <= PW'(N_LINES);
        start_q <= (start_q == AW'(N_LINES - 1)) ? '0 : start_q + AW'(1);
      end else begin
        gap_q <= gap_q - PW'(1);
      end
    end
  end

endmodule

module start_gap_remap_chk #(
  parameter int N_LINES = 64,
  parameter int AW = 6,
  parameter int PW = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          mv_req,
  input logic          mv_ack,
  input logic [PW-1:0] mv_dst,
  input logic [PW-1:0] phys_addr,
  input logic [AW-1:0] req_laddr,
  input logic [PW-1:0] gap_q,
  input logic [AW-1:0] start_q
);

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    mv_req && !mv_ack |=> mv_req && $stable(mv_dst) && $stable(start_q));

  p_drop_r5: assert property (@(posedge clk) disable iff (rst)
    mv_req && mv_ack |=> !mv_req);

  p_step_r6: assert property (@(posedge clk) disable iff (rst)
    mv_req && mv_ack && gap_q != '0 |=> gap_q == $past(gap_q) - PW'(1) && $stable(start_q));

  p_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    mv_req && mv_ack && gap_q == '0 |=> gap_q == PW'(N_LINES) &&
      start_q == (($past(start_q) == AW'(N_LINES - 1)) ? '0 : $past(start_q) + AW'(1)));

  p_frozen_r5: assert property (@(posedge clk) disable iff (rst)
    !(mv_req && mv_ack) |=> $stable(gap_q) && $stable(start_q));

  always @(posedge clk) begin
    if (!rst && int'(req_laddr) < N_LINES) begin
      p_gap_free_r7: assert (phys_addr != gap_q && int'(phys_addr) <= N_LINES);
    end
  end

endmodule

bind start_gap_remap start_gap_remap_chk #(.N_LINES(N_LINES), .AW(AW), .PW(PW)) u_chk (
  .clk(clk), .rst(rst), .mv_req(mv_req), .mv_ack(mv_ack), .mv_dst(mv_dst),
  .phys_addr(phys_addr), .req_laddr(req_laddr), .gap_q(gap_q), .start_q(start_q));

// File: tb/test_start_gap_remap.sv
module test_start_gap_remap;
  localparam int N  = 8;
  localparam int G  = 4;
  localparam int AW = $clog2(N);
  localparam int PW = $clog2(N + 1);

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_write = 0, mv_ack = 0;
  logic [AW-1:0] req_laddr = '0;
  logic [PW-1:0] phys_addr, mv_src, mv_dst;
  logic mv_req;

  int checks = 0, fails = 0;
  int ms = 0, mg = N, mcnt = 0;
  bit mpend = 0;
  bit ended = 0;

  always #5 clk = ~clk;

  start_gap_remap #(.N_LINES(N), .GAP_INTERVAL(G)) i_start_gap_remap (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_laddr(req_laddr), .phys_addr(phys_addr), .mv_req(mv_req),
    .mv_ack(mv_ack), .mv_src(mv_src), .mv_dst(mv_dst));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_phys(input int l);
    int t = (ms + l) % N;
    return (t >= mg) ? t + 1 : t;
  endfunction

  task automatic check_map(input string req);
    bit used[N+1];
    int bad_act = -1, bad_exp = -1;
    bit ok = 1;
    for (int i = 0; i <= N; i++) used[i] = 0;
    for (int l = 0; l < N; l++) begin
      req_laddr = AW'(l);
      #1;
      if (int'(phys_addr) != exp_phys(l) || int'(phys_addr) > N ||
          int'(phys_addr) == mg || used[phys_addr]) begin
        if (ok) begin bad_act = int'(phys_addr); bad_exp = exp_phys(l); end
        ok = 0;
      end
      if (int'(phys_addr) <= N) used[phys_addr] = 1;
    end
    chk(ok, req, bad_act, bad_exp);
  endtask

  task automatic access(input bit w);
    @(negedge clk);
    req_valid = 1; req_write = w;
    @(negedge clk);
    req_valid = 0; req_write = 0;
    if (w) begin
      if (!mpend && mcnt == G - 1) begin mpend = 1; mcnt = 0; end
      else if (mcnt != G - 1) mcnt++;
    end
  endtask

  task automatic ack_move();
    @(negedge clk);
    mv_ack = 1;
    @(negedge clk);
    mv_ack = 0;
    if (mg == 0) begin mg = N; ms = (ms + 1) % N; end
    else mg--;
    mpend = 0;
  endtask

  task automatic check_move_addrs(input string req);
    int es = (mg == 0) ? N : mg - 1;
    chk(int'(mv_src) == es, req, int'(mv_src), es);
    chk(int'(mv_dst) == mg, req, int'(mv_dst), mg);
  endtask

  task automatic t_reset();
    chk(mv_req == 0, "R1 mv_req", int'(mv_req), 0);
    check_map("R1 identity map");
  endtask

  task automatic t_trigger();
    for (int i = 0; i < G - 1; i++) access(1);
    chk(mv_req == 0, "R3 early", int'(mv_req), 0);
    access(1);
    chk(mv_req == 1, "R3 raise", int'(mv_req), 1);
    check_move_addrs("R4 addrs");
    repeat (3) @(negedge clk);
    chk(mv_req == 1, "R5 hold", int'(mv_req), 1);
    check_map("R5 map frozen");
    ack_move();
    chk(mv_req == 0, "R5 drop", int'(mv_req), 0);
    check_map("R2 after move");
  endtask

  task automatic t_reads();
    for (int i = 0; i < 3 * G; i++) access(0);
    chk(mv_req == 0, "R8 reads ignored", int'(mv_req), 0);
    for (int i = 0; i < G - 1; i++) access(1);
    chk(mv_req == 0, "R8 count after reads", int'(mv_req), 0);
    access(1);
    chk(mv_req == 1, "R3 after reads", int'(mv_req), 1);
    ack_move();
    check_map("R7 after move");
  endtask

  task automatic t_saturate();
    for (int i = 0; i < G; i++) access(1);
    chk(mv_req == 1, "R3 raise", int'(mv_req), 1);
    for (int i = 0; i < G + 2; i++) access(1);
    chk(mv_req == 1, "R8 pending writes", int'(mv_req), 1);
    ack_move();
    chk(mv_req == 0, "R5 drop", int'(mv_req), 0);
    access(1);
    chk(mv_req == 1, "R8 saturated trigger", int'(mv_req), 1);
    ack_move();
    check_map("R7 after saturate");
  endtask

  task automatic t_rotate();
    for (int m = 0; m < 2 * (N + 1) + 3; m++) begin
      for (int i = 0; i < G; i++) access(1);
      chk(mv_req == 1, "R3 rotate raise", int'(mv_req), 1);
      if (mg == 0) check_move_addrs("R4 wrap addrs");
      else check_move_addrs("R4 addrs");
      ack_move();
      if (mg == N) check_map("R6 wrap map");
      else check_map("R7 rotate map");
    end
    chk(ms == 2, "R6 start advanced", ms, 2);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_trigger();
    t_reads();
    t_saturate();
    t_rotate();
    finish_run();
  end

  initial begin
    #2000000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end
endmodule